// File: doc/BRIEF.md
# Byte-Lane Asynchronous Memory Port

This block models the device side of a 16-bit pseudo-static memory port. It decodes a 17-bit word address and five active-low controls: chip select, write strobe, read strobe, and one select per byte lane. From these it writes each byte lane of a small internal array on its own, and returns the stored bytes on a split data bus. The bidirectional pins are replaced by an input bus, an output bus and a 2-bit drive enable with one bit per byte lane. A surrounding pad ring or bus model turns those drive bits into tri-state control.

Writes are taken at the rising clock edge while chip select and the write strobe are both low. Reads are combinational from the array. The storage depth is a parameter and defaults to 64 words. Address bits above the depth are dropped, so addresses that differ only in those bits reach the same word. A standby output reports when the port is deselected.

Top module: `psram_port`

## Requirements
- R1: After reset every stored word reads as 0x0000.
- R2: At a rising clock edge with ce_ni=0, we_ni=0 and lb_ni=0, dat_i[7:0] is stored in the low byte of the addressed word.
- R3: At a rising clock edge with ce_ni=0, we_ni=0 and ub_ni=0, dat_i[15:8] is stored in the high byte of the addressed word.
- R4: During a write, a byte lane whose select is high keeps its previous contents.
- R5: A lane is driven when ce_ni=0, oe_ni=0, we_ni=1 and that lane's select is low. A driven lane carries the stored byte of the addressed word. An undriven lane reads as zero on dat_o.
- R6: dat_oe_o is 2'b00 whenever ce_ni=1, or oe_ni=1, or both byte selects are high, or ce_ni=0 and we_ni=0 together.
- R7: standby_o is 1 exactly when ce_ni=1 or both ub_ni and lb_ni are 1.
- R8: Address bits at and above log2(DEPTH) are ignored. With DEPTH=64, addresses equal in bits 5:0 select the same word.
- R9: A clock edge with ce_ni=1 or we_ni=1 changes no stored data.
- R10: dat_oe_o[0] enables the low lane (dat_o[7:0], selected by lb_ni). dat_oe_o[1] enables the high lane (dat_o[15:8], selected by ub_ni).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes are taken on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset, clears the array |
| addr_i | input | 17 | Word address |
| ce_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Read strobe, active low |
| ub_ni | input | 1 | High byte lane select, active low |
| lb_ni | input | 1 | Low byte lane select, active low |
| dat_i | input | 16 | Write data |
| dat_o | output | 16 | Read data, zero on undriven lanes |
| dat_oe_o | output | 2 | Per-lane drive enable, bit 0 low lane |
| standby_o | output | 1 | Deselected indication |

## Verification
A corrupted stored byte stays hidden until that word is read back with the lane selected. Once that read happens, the wrong value shows on dat_o in the same cycle, because the read path is combinational. A fault in the lane decode appears at once on dat_oe_o or standby_o, with no clock edge needed. A write that reaches the wrong lane or the wrong word is exposed on the first later read of either byte. The random traffic draws full 17-bit addresses, so aliased words are read back often.

// File: rtl/psram_pkg.sv
package psram_pkg;
  localparam int NUM_LANES = 2;

  typedef struct packed {
    logic       ce_n;
    logic       we_n;
    logic       oe_n;
    logic [NUM_LANES-1:0] be_n;  // bit 0 low lane, bit 1 high lane
  } port_ctl_t;
endpackage

// File: rtl/psram_decode.sv
module psram_decode
  import psram_pkg::*;
(
  input  port_ctl_t            ctl_i,
  output logic [NUM_LANES-1:0] wr_lane_o,
  output logic [NUM_LANES-1:0] drv_lane_o,
  output logic                 standby_o
);
  logic wr_cyc, rd_cyc;

  assign wr_cyc = ~ctl_i.ce_n & ~ctl_i.we_n;
  assign rd_cyc = ~ctl_i.ce_n & ~ctl_i.oe_n & ctl_i.we_n;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign wr_lane_o[l]  = wr_cyc & ~ctl_i.be_n[l];
    assign drv_lane_o[l] = rd_cyc & ~ctl_i.be_n[l];
  end

  assign standby_o = ctl_i.ce_n | (&ctl_i.be_n);
endmodule

// File: rtl/psram_lane.sv
module psram_lane #(
  parameter int LANE_W = 8,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LANE_W-1:0] wdat_i,
  output logic [LANE_W-1:0] rdat_o
);
  logic [LANE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[idx_i] <= wdat_i;
    end
  end

  assign rdat_o = mem_q[idx_i];
endmodule

// File: rtl/psram_port.sv
module psram_port
  import psram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LANE_W = 8,
  parameter int DEPTH  = 64,  // power of two, at most 2**ADDR_W
  localparam int DATA_W = NUM_LANES * LANE_W,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 ce_ni,
  input  logic                 we_ni,
  input  logic                 oe_ni,
  input  logic                 ub_ni,
  input  logic                 lb_ni,
  input  logic [DATA_W-1:0]    dat_i,
  output logic [DATA_W-1:0]    dat_o,
  output logic [NUM_LANES-1:0] dat_oe_o,
  output logic                 standby_o
);
  port_ctl_t            ctl;
  logic [NUM_LANES-1:0] wr_lane, drv_lane;
  logic [IDX_W-1:0]     idx;

  assign ctl = '{ce_n: ce_ni, we_n: we_ni, oe_n: oe_ni, be_n: {ub_ni, lb_ni}};
  assign idx = addr_i[IDX_W-1:0];

  // upper address bits alias onto the small array
  if (IDX_W < ADDR_W) begin : g_alias
    logic unused_addr_hi;
    assign unused_addr_hi = ^addr_i[ADDR_W-1:IDX_W];
  end

  psram_decode u_decode (
    .ctl_i      (ctl),
    .wr_lane_o  (wr_lane),
    .drv_lane_o (drv_lane),
    .standby_o  (standby_o)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] rdat;

    psram_lane #(.LANE_W(LANE_W), .DEPTH(DEPTH)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_lane[l]),
      .idx_i   (idx),
      .wdat_i  (dat_i[l*LANE_W +: LANE_W]),
      .rdat_o  (rdat)
    );

    assign dat_o[l*LANE_W +: LANE_W] = drv_lane[l] ? rdat : '0;
  end

  assign dat_oe_o = drv_lane;
endmodule

// File: rtl/psram_port_chk.sv
module psram_port_chk #(
  parameter int LANE_W = 8,
  parameter int IDX_W  = 6,
  localparam int DATA_W = 2 * LANE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IDX_W-1:0]  idx_i,
  input logic              ce_ni,
  input logic              we_ni,
  input logic              oe_ni,
  input logic              ub_ni,
  input logic              lb_ni,
  input logic [DATA_W-1:0] dat_i,
  input logic [DATA_W-1:0] dat_o,
  input logic [1:0]        dat_oe_o,
  input logic              standby_o
);
  // R6
  deselect_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> (dat_oe_o == 2'b00));

  // R6
  write_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !we_ni) |-> (dat_oe_o == 2'b00));

  // R6
  oe_off_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (dat_oe_o == 2'b00));

  // R10
  hi_lane_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_oe_o[1] |-> !ub_ni);

  // R10
  lo_lane_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_oe_o[0] |-> !lb_ni);

  // R5
  undriven_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dat_oe_o[0] |-> (dat_o[LANE_W-1:0] == '0));

  // R7
  standby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || (ub_ni && lb_ni)) |-> standby_o);

  // R2
  lo_write_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !we_ni && !lb_ni) |=>
      (!(idx_i == $past(idx_i) && !ce_ni && we_ni && !oe_ni && !lb_ni)
       || dat_o[LANE_W-1:0] == $past(dat_i[LANE_W-1:0])));

  // R3
  hi_write_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !we_ni && !ub_ni) |=>
      (!(idx_i == $past(idx_i) && !ce_ni && we_ni && !oe_ni && !ub_ni)
       || dat_o[DATA_W-1:LANE_W] == $past(dat_i[DATA_W-1:LANE_W])));
endmodule

bind psram_port psram_port_chk #(.LANE_W(LANE_W), .IDX_W(IDX_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .idx_i     (addr_i[IDX_W-1:0]),
  .ce_ni     (ce_ni),
  .we_ni     (we_ni),
  .oe_ni     (oe_ni),
  .ub_ni     (ub_ni),
  .lb_ni     (lb_ni),
  .dat_i     (dat_i),
  .dat_o     (dat_o),
  .dat_oe_o  (dat_oe_o),
  .standby_o (standby_o)
);

// File: tb/psram_port_tb_top.sv
module psram_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [16:0] addr_i = '0;
  logic        ce_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1, ub_ni = 1'b1, lb_ni = 1'b1;
  logic [15:0] dat_i = '0;
  logic [15:0] dat_o;
  logic [1:0]  dat_oe_o;
  logic        standby_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] model [64];

  always #2.5 clk = ~clk;

  psram_port #(.DEPTH(64)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .ce_ni(ce_ni), .we_ni(we_ni),
    .oe_ni(oe_ni), .ub_ni(ub_ni), .lb_ni(lb_ni), .dat_i(dat_i), .dat_o(dat_o),
    .dat_oe_o(dat_oe_o), .standby_o(standby_o)
  );

  function automatic logic [1:0] exp_oe(logic ce, logic we, logic oe, logic ub, logic lb);
    logic drv = !ce && !oe && we;
    return {drv && !ub, drv && !lb};
  endfunction

  function automatic logic [15:0] exp_dat(logic [1:0] en, logic [15:0] word);
    return {en[1] ? word[15:8] : 8'h00, en[0] ? word[7:0] : 8'h00};
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // drive one cycle at the falling edge, check mid-phase, update model after the rising edge
  task automatic cyc(string req, logic [16:0] a, logic ce, logic we, logic oe,
                     logic ub, logic lb, logic [15:0] d);
    logic [1:0] eo;
    @(negedge clk);
    addr_i = a; ce_ni = ce; we_ni = we; oe_ni = oe; ub_ni = ub; lb_ni = lb; dat_i = d;
    #1;
    eo = exp_oe(ce, we, oe, ub, lb);
    chk(req, "dat_oe_o", 32'(dat_oe_o), 32'(eo));
    chk(req, "dat_o", 32'(dat_o), 32'(exp_dat(eo, model[a[5:0]])));
    chk(req, "standby_o", 32'(standby_o), 32'(ce || (ub && lb)));
    @(posedge clk);
    if (!ce && !we) begin
      if (!lb) model[a[5:0]][7:0]  = d[7:0];
      if (!ub) model[a[5:0]][15:8] = d[15:8];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: cleared after reset
    cyc("R1", 17'd0,  0, 1, 0, 0, 0, 16'h0);
    cyc("R1", 17'd63, 0, 1, 0, 0, 0, 16'h0);
    // R2: low lane write
    cyc("R6", 17'd5, 0, 0, 1, 1, 0, 16'hA1B2);
    cyc("R2", 17'd5, 0, 1, 0, 0, 0, 16'h0);
    // R3: high lane write
    cyc("R6", 17'd5, 0, 0, 0, 0, 1, 16'hC3D4);
    cyc("R3", 17'd5, 0, 1, 0, 0, 0, 16'h0);
    // R4: unselected lane keeps old byte
    cyc("R6", 17'd9, 0, 0, 1, 0, 0, 16'hFFFF);
    cyc("R6", 17'd9, 0, 0, 1, 1, 0, 16'h0000);
    cyc("R4", 17'd9, 0, 1, 0, 0, 0, 16'h0);
    // R9: no write when deselected or write strobe high
    cyc("R7", 17'd9, 1, 0, 0, 0, 0, 16'h1234);
    cyc("R9", 17'd9, 0, 1, 1, 0, 0, 16'h5678);
    cyc("R9", 17'd9, 0, 1, 0, 0, 0, 16'h0);
    // R8: aliasing of upper address bits
    cyc("R6", 17'(5 + 64*7), 0, 0, 1, 0, 0, 16'h5566);
    cyc("R8", 17'd5, 0, 1, 0, 0, 0, 16'h0);
    cyc("R8", 17'(5 + 64*100), 0, 1, 0, 0, 0, 16'h0);
    // R10: single lane drive
    cyc("R10", 17'd5, 0, 1, 0, 0, 1, 16'h0);
    cyc("R10", 17'd5, 0, 1, 0, 1, 0, 16'h0);
    // R6, R7: float conditions and standby
    cyc("R6", 17'd5, 0, 1, 1, 0, 0, 16'h0);
    cyc("R7", 17'd5, 0, 1, 0, 1, 1, 16'h0);
    cyc("R5", 17'd5, 0, 1, 0, 0, 0, 16'h0);

    // R5/R6/R7 random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [16:0] a;
      a = 17'($urandom());
      if (n % 2 == 0) a = {a[16:6], 6'($urandom_range(0, 7))};
      cyc("R5/R6/R7", a, ($urandom() % 6) == 0, ($urandom() % 3) != 0,
          ($urandom() % 5) == 0, ($urandom() % 4) == 0, ($urandom() % 4) == 0,
          16'($urandom()));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule